// File: doc/BRIEF.md
# Per-page writeback rate monitor

This block sits on the path between the last-level cache and a phase-change main memory. It watches every dirty-line writeback and flags the physical pages that are being worn faster than the memory can tolerate. Each writeback adds one to a counter for its 4 KB page. A line is 64 bytes, so one count stands for 64 bytes of write traffic. The test is done per page rather than per line or per instruction. An attacker therefore cannot hide by spreading writes over all the lines of one page, and cannot hide by diluting the write rate with filler instructions.

The counters are kept in a small set-associative counter cache with LRU replacement. When a new page displaces a resident one, the displaced count is written to a reserved scratch region of main memory. The new page's count is then read back from that region, so no count is ever lost. Counts are never cleared on a context switch.

At every epoch boundary, each resident page whose count exceeds a programmable threshold is sent out once on a valid/ready stream, so that it can be moved to DRAM. All resident counts then restart from zero. Spilled pages are tested when they are refilled. The threshold corresponds to the lifetime-preserving per-page rate of about 1.2 KB/s, which is roughly 19 writebacks per second. With the default one-second epoch at 250 MHz, the threshold is 19.

Top module: `pgwr_rate_monitor`

## Requirements
- R1: The page index is the writeback address shifted right by PAGE_SHIFT (12). Its low log2(SETS) bits select the set and the remaining bits form the tag. Every accepted writeback adds exactly one to the count of its page, whichever line of the page it targets.
- R2: A writeback to a resident page causes no scratch traffic. A miss in a set that has a free way fills the lowest-numbered free way with one scratch read and no scratch write.
- R3: A miss in a full set evicts the least recently used way. The victim's count is first written to scratch address SCR_BASE + 4*page. Only after that write is accepted is the new page's count read from SCR_BASE + 4*page.
- R4: A refilled count greater than the threshold makes the block report that page on the anomaly stream, after which the entry restarts at 1. Otherwise the entry holds the refilled count plus one.
- R5: Counters are CNT_W bits wide and stay at all-ones instead of wrapping.
- R6: EPOCH_CYCLES cycles after reset, and every EPOCH_CYCLES cycles after that, the block scans the cache. The scan order is set-major, with ascending way. Each resident entry whose count exceeds the threshold is reported exactly once. Every resident count is then set to zero, while valid bits and LRU order are kept.
- R7: The writeback input holds ready low while a spill, a refill, a report or a scan is in progress. Each accepted writeback is counted exactly once.
- R8: Once the anomaly output is valid, it stays valid with the same page until it is accepted.
- R9: Once a scratch request is valid, it stays valid with the same address, direction and data until it is accepted. At most one read is outstanding at a time.
- R10: A synchronous active-low reset invalidates every entry, restores the LRU order and restarts the epoch timer. After reset, ready is high and no request or report is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_valid_i | input | 1 | Writeback present |
| wb_ready_o | output | 1 | Writeback accepted when high together with valid |
| wb_addr_i | input | ADDR_W | Physical address of the written-back line |
| thresh_i | input | CNT_W | Per-page writeback budget per epoch |
| scr_req_valid_o | output | 1 | Scratch request valid |
| scr_req_ready_i | input | 1 | Scratch request accepted |
| scr_req_write_o | output | 1 | 1 = spill write, 0 = refill read |
| scr_req_addr_o | output | ADDR_W | Scratch word address |
| scr_req_wdata_o | output | CNT_W | Count being spilled |
| scr_rsp_valid_i | input | 1 | Refill data valid |
| scr_rsp_rdata_i | input | CNT_W | Refilled count |
| anom_valid_o | output | 1 | Anomalous page report valid |
| anom_ready_i | input | 1 | Report accepted |
| anom_page_o | output | ADDR_W-PAGE_SHIFT | Page index of the anomalous page |

## Verification
The bench builds the block with 4 sets of 2 ways, 8-bit counters and a 2000-cycle epoch. With this shape, three pages are enough to force an eviction in one set. The shape also lets 300 writebacks drive a counter into saturation, and lets an epoch scan be reached a few thousand cycles after reset. Scratch latency and the ready inputs of both outgoing streams are varied, which exposes the stall and hold behaviour. Every expected spill address, spill value and reported page is derived arithmetically from the page numbers used.

// File: rtl/pgwr_pkg.sv
// Shared types for the per-page writeback rate monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package pgwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,       // accepting writebacks
        ST_SPILL,      // writing the victim count to scratch
        ST_FILL_REQ,   // issuing the refill read
        ST_FILL_WAIT,  // waiting for refill data
        ST_FILL_RPT,   // reporting a refilled page over budget
        ST_SCAN,       // epoch scan, one entry per cycle
        ST_SCAN_RPT    // reporting a resident page over budget
    } mon_state_t;

endpackage

// File: rtl/pgwr_epoch_timer.sv
// Free-running epoch timer: pulses tick_o for one cycle every EPOCH_CYCLES.
// Assumes: EPOCH_CYCLES >= 2; synchronous active-low reset restarts the count.
module pgwr_epoch_timer #(
    parameter int unsigned EPOCH_CYCLES = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned TW = $clog2(EPOCH_CYCLES);

    logic [TW-1:0] cnt_q;

    // last count of the epoch raises the tick
    assign tick_o = (cnt_q == TW'(EPOCH_CYCLES - 1));

    // count cycles and wrap at the epoch length
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pgwr_way_pick.sv
// Tag match and victim choice for one set of the counter cache.
// Assumes: ages form a permutation of 0..WAYS-1 (oldest = WAYS-1);
// lowest-numbered matching or free way wins.
module pgwr_way_pick #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = 2,
    parameter int unsigned TAG_W = 16
) (
    input  logic [WAYS-1:0]             vld_i,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
    input  logic [WAYS-1:0][WAY_W-1:0]  ages_i,
    input  logic [TAG_W-1:0]            tag_i,
    output logic                        hit_o,
    output logic [WAY_W-1:0]            hit_way_o,
    output logic [WAY_W-1:0]            vic_way_o
);
    // find the lowest way holding the looked-up tag
    always_comb begin
        hit_o     = 1'b0;
        hit_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (vld_i[w] && (tags_i[w] == tag_i)) begin
                hit_o     = 1'b1;
                hit_way_o = WAY_W'(w);
            end
        end
    end

    // prefer the lowest free way, else the oldest one
    always_comb begin
        vic_way_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (ages_i[w] == WAY_W'(WAYS - 1)) vic_way_o = WAY_W'(w);
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld_i[w]) vic_way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/pgwr_lru_touch.sv
// Age update for one set: the touched way becomes youngest, younger ways age by one.
// Assumes: input ages are a permutation of 0..WAYS-1, so the output is too.
module pgwr_lru_touch #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned WAY_W = 2
) (
    input  logic [WAYS-1:0][WAY_W-1:0] age_i,
    input  logic [WAY_W-1:0]           way_i,
    output logic [WAYS-1:0][WAY_W-1:0] age_o
);
    logic [WAY_W-1:0] ref_age;

    // age of the way being touched
    assign ref_age = age_i[way_i];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        // per-way next age
        assign age_o[w] = (WAY_W'(w) == way_i)  ? '0 :
                          (age_i[w] < ref_age)  ? age_i[w] + 1'b1 :
                                                  age_i[w];
    end
endmodule

// File: rtl/pgwr_rate_monitor.sv
// Per-page writeback rate monitor.
// Counts dirty writebacks per physical page in a set-associative counter
// cache, spills and refills counts through a scratch memory port, and
// reports pages over budget at epoch ends and on refill.
// Assumes: SETS and WAYS are powers of two, both >= 2; PAGE_SHIFT >= 2;
// the scratch port returns exactly one response per read, never for writes.
module pgwr_rate_monitor
    import pgwr_pkg::*;
#(
    parameter int unsigned ADDR_W       = 32,
    parameter int unsigned PAGE_SHIFT   = 12,
    parameter int unsigned SETS         = 16,
    parameter int unsigned WAYS         = 4,
    parameter int unsigned CNT_W        = 16,
    parameter int unsigned EPOCH_CYCLES = 250_000_000,
    parameter logic [ADDR_W-1:0] SCR_BASE = 'h8000_0000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wb_valid_i,
    output logic                         wb_ready_o,
    input  logic [ADDR_W-1:0]            wb_addr_i,
    input  logic [CNT_W-1:0]             thresh_i,
    output logic                         scr_req_valid_o,
    input  logic                         scr_req_ready_i,
    output logic                         scr_req_write_o,
    output logic [ADDR_W-1:0]            scr_req_addr_o,
    output logic [CNT_W-1:0]             scr_req_wdata_o,
    input  logic                         scr_rsp_valid_i,
    input  logic [CNT_W-1:0]             scr_rsp_rdata_i,
    output logic                         anom_valid_o,
    input  logic                         anom_ready_i,
    output logic [ADDR_W-PAGE_SHIFT-1:0] anom_page_o
);
    localparam int unsigned PAGE_W = ADDR_W - PAGE_SHIFT;
    localparam int unsigned SET_W  = $clog2(SETS);
    localparam int unsigned WAY_W  = $clog2(WAYS);
    localparam int unsigned TAG_W  = PAGE_W - SET_W;
    localparam int unsigned ENT    = SETS * WAYS;
    localparam int unsigned ENT_W  = SET_W + WAY_W;

    // counter cache storage
    logic [WAYS-1:0]             vld_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]  tag_q [SETS];
    logic [WAYS-1:0][CNT_W-1:0]  cnt_q [SETS];
    logic [WAYS-1:0][WAY_W-1:0]  age_q [SETS];

    mon_state_t        state_q;
    logic              flush_pend_q;
    logic [ENT_W-1:0]  scan_ptr_q;
    logic [SET_W-1:0]  lat_set_q;
    logic [TAG_W-1:0]  lat_tag_q;
    logic [WAY_W-1:0]  lat_way_q;
    logic [PAGE_W-1:0] spill_page_q;
    logic [CNT_W-1:0]  spill_cnt_q;

    logic              tick;
    logic [PAGE_W-1:0] wb_page;
    logic [SET_W-1:0]  wb_set;
    logic [TAG_W-1:0]  wb_tag;
    logic              hit;
    logic [WAY_W-1:0]  hit_way;
    logic [WAY_W-1:0]  vic_way;
    logic [SET_W-1:0]  touch_set;
    logic [WAY_W-1:0]  touch_way;
    logic [WAYS-1:0][WAY_W-1:0] touched_ages;
    logic [SET_W-1:0]  sc_set;
    logic [WAY_W-1:0]  sc_way;
    logic              sc_over;
    logic [PAGE_W-1:0] sc_page;
    logic [PAGE_W-1:0] fill_page;
    logic              scan_last;
    logic              unused_line_bits;

    // saturating increment of a count
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

    // split the writeback address into page, set and tag
    assign wb_page          = wb_addr_i[ADDR_W-1:PAGE_SHIFT];
    assign wb_set           = wb_page[SET_W-1:0];
    assign wb_tag           = wb_page[PAGE_W-1:SET_W];
    assign unused_line_bits = ^wb_addr_i[PAGE_SHIFT-1:0];

    // scan pointer split and the entry it addresses
    assign sc_set    = scan_ptr_q[ENT_W-1:WAY_W];
    assign sc_way    = scan_ptr_q[WAY_W-1:0];
    assign sc_over   = vld_q[sc_set][sc_way] && (cnt_q[sc_set][sc_way] > thresh_i);
    assign sc_page   = {tag_q[sc_set][sc_way], sc_set};
    assign scan_last = (scan_ptr_q == ENT_W'(ENT - 1));
    assign fill_page = {lat_tag_q, lat_set_q};

    // LRU touch target: live lookup when idle, latched miss otherwise
    assign touch_set = (state_q == ST_IDLE) ? wb_set  : lat_set_q;
    assign touch_way = (state_q == ST_IDLE) ? hit_way : lat_way_q;

    pgwr_epoch_timer #(
        .EPOCH_CYCLES(EPOCH_CYCLES)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    pgwr_way_pick #(
        .WAYS (WAYS),
        .WAY_W(WAY_W),
        .TAG_W(TAG_W)
    ) pick_i (
        .vld_i    (vld_q[wb_set]),
        .tags_i   (tag_q[wb_set]),
        .ages_i   (age_q[wb_set]),
        .tag_i    (wb_tag),
        .hit_o    (hit),
        .hit_way_o(hit_way),
        .vic_way_o(vic_way)
    );

    pgwr_lru_touch #(
        .WAYS (WAYS),
        .WAY_W(WAY_W)
    ) lru_i (
        .age_i(age_q[touch_set]),
        .way_i(touch_way),
        .age_o(touched_ages)
    );

    // handshake outputs decoded from the state
    always_comb begin
        wb_ready_o      = (state_q == ST_IDLE) && !flush_pend_q;
        scr_req_valid_o = (state_q == ST_SPILL) || (state_q == ST_FILL_REQ);
        scr_req_write_o = (state_q == ST_SPILL);
        scr_req_addr_o  = SCR_BASE + ADDR_W'({(state_q == ST_SPILL) ? spill_page_q : fill_page, 2'b00});
        scr_req_wdata_o = spill_cnt_q;
        anom_valid_o    = (state_q == ST_FILL_RPT) || (state_q == ST_SCAN_RPT);
        anom_page_o     = (state_q == ST_FILL_RPT) ? fill_page : sc_page;
    end

    // control sequence and counter cache update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            flush_pend_q <= 1'b0;
            scan_ptr_q   <= '0;
            lat_set_q    <= '0;
            lat_tag_q    <= '0;
            lat_way_q    <= '0;
            spill_page_q <= '0;
            spill_cnt_q  <= '0;
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (flush_pend_q) begin
                        state_q      <= ST_SCAN;
                        scan_ptr_q   <= '0;
                        flush_pend_q <= 1'b0;
                    end else if (wb_valid_i) begin
                        if (hit) begin
                            cnt_q[wb_set][hit_way] <= sat_inc(cnt_q[wb_set][hit_way]);
                            age_q[wb_set]          <= touched_ages;
                        end else begin
                            lat_set_q    <= wb_set;
                            lat_tag_q    <= wb_tag;
                            lat_way_q    <= vic_way;
                            spill_page_q <= {tag_q[wb_set][vic_way], wb_set};
                            spill_cnt_q  <= cnt_q[wb_set][vic_way];
                            state_q      <= vld_q[wb_set][vic_way] ? ST_SPILL : ST_FILL_REQ;
                        end
                    end
                end
                ST_SPILL: begin
                    if (scr_req_ready_i) state_q <= ST_FILL_REQ;
                end
                ST_FILL_REQ: begin
                    if (scr_req_ready_i) state_q <= ST_FILL_WAIT;
                end
                ST_FILL_WAIT: begin
                    if (scr_rsp_valid_i) begin
                        if (scr_rsp_rdata_i > thresh_i) begin
                            state_q <= ST_FILL_RPT;
                        end else begin
                            vld_q[lat_set_q][lat_way_q] <= 1'b1;
                            tag_q[lat_set_q][lat_way_q] <= lat_tag_q;
                            cnt_q[lat_set_q][lat_way_q] <= sat_inc(scr_rsp_rdata_i);
                            age_q[lat_set_q]            <= touched_ages;
                            state_q                     <= ST_IDLE;
                        end
                    end
                end
                ST_FILL_RPT: begin
                    if (anom_ready_i) begin
                        vld_q[lat_set_q][lat_way_q] <= 1'b1;
                        tag_q[lat_set_q][lat_way_q] <= lat_tag_q;
                        cnt_q[lat_set_q][lat_way_q] <= CNT_W'(1);
                        age_q[lat_set_q]            <= touched_ages;
                        state_q                     <= ST_IDLE;
                    end
                end
                ST_SCAN: begin
                    if (sc_over) begin
                        state_q <= ST_SCAN_RPT;
                    end else begin
                        cnt_q[sc_set][sc_way] <= '0;
                        scan_ptr_q            <= scan_ptr_q + 1'b1;
                        if (scan_last) state_q <= ST_IDLE;
                    end
                end
                ST_SCAN_RPT: begin
                    if (anom_ready_i) begin
                        cnt_q[sc_set][sc_way] <= '0;
                        scan_ptr_q            <= scan_ptr_q + 1'b1;
                        state_q               <= scan_last ? ST_IDLE : ST_SCAN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
            if (tick) flush_pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pgwr_rate_monitor_chk.sv
// Port-level protocol checker for the per-page writeback rate monitor.
// Assumes: attached by the bind below; all properties idle during reset.
module pgwr_rate_monitor_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PAGE_W = 20,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wb_ready_o,
    input logic              scr_req_valid_o,
    input logic              scr_req_ready_i,
    input logic              scr_req_write_o,
    input logic [ADDR_W-1:0] scr_req_addr_o,
    input logic [CNT_W-1:0]  scr_req_wdata_o,
    input logic              anom_valid_o,
    input logic              anom_ready_i,
    input logic [PAGE_W-1:0] anom_page_o
);
    // R7
    req_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scr_req_valid_o |-> !wb_ready_o);

    // R7
    rpt_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        anom_valid_o |-> !wb_ready_o);

    // R7
    one_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scr_req_valid_o, anom_valid_o}));

    // R8
    rpt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (anom_valid_o && !anom_ready_i) |=> (anom_valid_o && $stable(anom_page_o)));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_req_valid_o && !scr_req_ready_i) |=>
        (scr_req_valid_o && $stable(scr_req_write_o) && $stable(scr_req_addr_o) &&
         $stable(scr_req_wdata_o)));

    // R3
    spill_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_req_valid_o && scr_req_ready_i && scr_req_write_o) |=>
        (scr_req_valid_o && !scr_req_write_o));
endmodule

bind pgwr_rate_monitor pgwr_rate_monitor_chk #(
    .ADDR_W(ADDR_W),
    .PAGE_W(ADDR_W - PAGE_SHIFT),
    .CNT_W (CNT_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wb_ready_o     (wb_ready_o),
    .scr_req_valid_o(scr_req_valid_o),
    .scr_req_ready_i(scr_req_ready_i),
    .scr_req_write_o(scr_req_write_o),
    .scr_req_addr_o (scr_req_addr_o),
    .scr_req_wdata_o(scr_req_wdata_o),
    .anom_valid_o   (anom_valid_o),
    .anom_ready_i   (anom_ready_i),
    .anom_page_o    (anom_page_o)
);

// File: tb/pgwr_rate_monitor_tb_top.sv
`timescale 1ns/1ps
// Directed sweeps over a 4-set, 2-way, 8-bit-counter build of the monitor.
module pgwr_rate_monitor_tb_top;
    localparam int          ADDR_W = 32;
    localparam int          PSH    = 12;
    localparam int          CW     = 8;
    localparam int          EPOCH  = 2000;
    localparam logic [31:0] BASE   = 32'h0010_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wb_valid = 1'b0;
    logic [31:0] wb_addr = '0;
    logic [CW-1:0] thr = 8'd5;
    logic req_rdy = 1'b1;
    logic rsp_valid = 1'b0;
    logic [CW-1:0] rsp_data = '0;
    logic anom_rdy = 1'b1;
    logic wb_ready_o, scr_req_valid_o, scr_req_write_o, anom_valid_o;
    logic [31:0] scr_req_addr_o;
    logic [CW-1:0] scr_req_wdata_o;
    logic [19:0] anom_page_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int rsp_delay = 2;
    int spill_n = 0, fill_n = 0, an_n = 0;
    logic [31:0] last_sp_addr = '0, last_fl_addr = '0;
    int last_sp_data = 0;
    int an_log [0:63];
    logic [CW-1:0] smem [0:63];
    logic pend = 1'b0;
    int pend_idx = 0, dly = 0;

    always #2 clk = ~clk;

    pgwr_rate_monitor #(
        .ADDR_W(ADDR_W), .PAGE_SHIFT(PSH), .SETS(4), .WAYS(2), .CNT_W(CW),
        .EPOCH_CYCLES(EPOCH), .SCR_BASE(BASE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wb_valid_i(wb_valid), .wb_ready_o(wb_ready_o), .wb_addr_i(wb_addr),
        .thresh_i(thr),
        .scr_req_valid_o(scr_req_valid_o), .scr_req_ready_i(req_rdy),
        .scr_req_write_o(scr_req_write_o), .scr_req_addr_o(scr_req_addr_o),
        .scr_req_wdata_o(scr_req_wdata_o),
        .scr_rsp_valid_i(rsp_valid), .scr_rsp_rdata_i(rsp_data),
        .anom_valid_o(anom_valid_o), .anom_ready_i(anom_rdy), .anom_page_o(anom_page_o)
    );

    // cycle count since reset release
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // scratch memory model with programmable read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            pend      <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (scr_req_valid_o && req_rdy) begin
                if (scr_req_write_o) begin
                    smem[(scr_req_addr_o - BASE) >> 2] <= scr_req_wdata_o;
                    spill_n      <= spill_n + 1;
                    last_sp_addr <= scr_req_addr_o;
                    last_sp_data <= int'(scr_req_wdata_o);
                end else begin
                    pend         <= 1'b1;
                    pend_idx     <= int'((scr_req_addr_o - BASE) >> 2);
                    dly          <= rsp_delay;
                    fill_n       <= fill_n + 1;
                    last_fl_addr <= scr_req_addr_o;
                end
            end
            if (pend) begin
                if (dly == 0) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= smem[pend_idx];
                    pend      <= 1'b0;
                end else begin
                    dly <= dly - 1;
                end
            end
        end
    end

    // anomaly stream collector
    always @(posedge clk) begin
        if (rst_n && anom_valid_o && anom_rdy) begin
            an_log[an_n] <= int'(anom_page_o);
            an_n         <= an_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) smem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_wb(input logic [31:0] a);
        @(negedge clk);
        wb_valid = 1'b1;
        wb_addr  = a;
        while (!wb_ready_o) @(negedge clk);
        @(negedge clk);
        wb_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!wb_ready_o) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int f0, s0, a0, busy, first_cyc;
        // ---- reset state (R10)
        do_reset();
        @(negedge clk);
        chk(wb_ready_o == 1'b1, "R10 ready after reset", wb_ready_o, 1);
        chk(scr_req_valid_o == 1'b0, "R10 no request after reset", scr_req_valid_o, 0);
        chk(anom_valid_o == 1'b0, "R10 no report after reset", anom_valid_o, 0);

        // ---- fills, hits, LRU spill, refill report (R1 R2 R3 R4)
        thr = 8'd5; rsp_delay = 2;
        f0 = fill_n; s0 = spill_n; a0 = an_n;
        send_wb(32'h0000_5000); wait_idle();
        chk(fill_n - f0 == 1 && spill_n == s0, "R2 cold miss one read", fill_n - f0, 1);
        chk(last_fl_addr == BASE + 32'd20, "R3 fill address page 5", int'(last_fl_addr - BASE), 20);
        for (int k = 1; k < 7; k++) begin send_wb(32'h0000_5000 + 32'(k * 64)); wait_idle(); end
        chk(fill_n - f0 == 1, "R1 lines of one page hit", fill_n - f0, 1);
        send_wb(32'h0000_9000); wait_idle();
        chk(spill_n == s0 && fill_n - f0 == 2, "R2 free way no spill", spill_n - s0, 0);
        send_wb(32'h0000_D000); wait_idle();
        chk(last_sp_addr == BASE + 32'd20, "R3 LRU victim page 5", int'(last_sp_addr - BASE), 20);
        chk(last_sp_data == 7, "R1 seven writebacks counted", last_sp_data, 7);
        chk(last_fl_addr == BASE + 32'd52, "R3 fill address page 13", int'(last_fl_addr - BASE), 52);
        send_wb(32'h0000_5080); wait_idle();
        chk(last_sp_addr == BASE + 32'd36 && last_sp_data == 1, "R3 victim page 9 count 1",
            int'(last_sp_addr - BASE), 36);
        chk(an_n - a0 == 1, "R4 refill over budget reported", an_n - a0, 1);
        chk(an_log[a0] == 5, "R4 reported page", an_log[a0], 5);
        while (cyc < EPOCH + 60) @(negedge clk);
        chk(an_n - a0 == 1, "R6 nothing over budget at epoch", an_n - a0, 1);

        // ---- epoch scan, order, hold, clear (R6 R8)
        do_reset();
        thr = 8'd3; anom_rdy = 1'b0; a0 = an_n;
        for (int k = 0; k < 4; k++) begin send_wb(32'h0000_2000 + 32'(k * 64)); wait_idle(); end
        for (int k = 0; k < 3; k++) begin send_wb(32'h0000_3000 + 32'(k * 64)); wait_idle(); end
        for (int k = 0; k < 10; k++) begin send_wb(32'h0000_6000 + 32'(k * 64)); wait_idle(); end
        for (int i = 0; i < 2500 && !anom_valid_o; i++) @(negedge clk);
        first_cyc = cyc;
        chk(first_cyc >= EPOCH && first_cyc <= EPOCH + 12, "R6 report at epoch", first_cyc, EPOCH);
        chk(anom_valid_o && anom_page_o == 20'd2, "R6 first report page 2", int'(anom_page_o), 2);
        repeat (5) @(negedge clk);
        chk(anom_valid_o && anom_page_o == 20'd2, "R8 report held under backpressure",
            int'(anom_page_o), 2);
        anom_rdy = 1'b1;
        repeat (20) @(negedge clk);
        chk(an_n - a0 == 2, "R6 exactly two pages over budget", an_n - a0, 2);
        chk(an_log[a0 + 1] == 6, "R6 second report page 6", an_log[a0 + 1], 6);
        send_wb(32'h0000_2000); wait_idle();
        send_wb(32'h0000_A000); wait_idle();
        chk(last_sp_addr == BASE + 32'd24 && last_sp_data == 0, "R6 count cleared at epoch",
            last_sp_data, 0);

        // ---- saturation (R5)
        do_reset();
        thr = 8'd254; a0 = an_n;
        for (int k = 0; k < 300; k++) begin send_wb(32'h0000_1000 + 32'((k % 64) * 64)); wait_idle(); end
        send_wb(32'h0000_5000); wait_idle();
        send_wb(32'h0000_9000); wait_idle();
        chk(last_sp_addr == BASE + 32'd4 && last_sp_data == 255, "R5 count saturates",
            last_sp_data, 255);
        send_wb(32'h0000_1000); wait_idle();
        chk(an_n - a0 == 1 && an_log[a0] == 1, "R4 saturated refill reported", an_n - a0, 1);

        // ---- stall during slow refill, no drop (R7)
        do_reset();
        thr = 8'd200; rsp_delay = 6;
        @(negedge clk);
        wb_valid = 1'b1; wb_addr = 32'h0000_7000;
        @(negedge clk);
        wb_addr = 32'h0000_7040;
        busy = 0;
        while (!wb_ready_o) begin busy++; @(negedge clk); end
        @(negedge clk);
        wb_valid = 1'b0;
        chk(busy >= 7, "R7 ready low during refill", busy, 7);
        wait_idle();
        send_wb(32'h0000_B000); wait_idle();
        send_wb(32'h0000_F000); wait_idle();
        chk(last_sp_addr == BASE + 32'd28 && last_sp_data == 2, "R7 held writeback counted once",
            last_sp_data, 2);

        // ---- reset invalidates, request hold (R10 R9)
        rsp_delay = 1;
        do_reset();
        f0 = fill_n; s0 = spill_n;
        req_rdy = 1'b0;
        send_wb(32'h0000_B000);
        repeat (4) @(negedge clk);
        chk(scr_req_valid_o && !scr_req_write_o && scr_req_addr_o == BASE + 32'd44,
            "R9 request held", int'(scr_req_addr_o - BASE), 44);
        req_rdy = 1'b1;
        wait_idle();
        chk(fill_n - f0 == 1 && spill_n == s0, "R10 resident page missed after reset",
            fill_n - f0, 1);

        finish_run();
    end
endmodule